// File: doc/BRIEF.md
# Time-Multiplexed Recursive Low-Pass Filter

This block low-pass filters a stream of baseband in-phase and quadrature samples in which several channels share one wire by taking turns. Each incoming sample carries a slot number saying which channel it belongs to. Every slot keeps its own short history of past inputs and outputs. A single adder-and-shift datapath per lane serves every slot, and the history of the addressed slot is read, combined with the new sample and written back in the same cycle. The I and Q lanes run side by side, with identical and independent state.

The filter has a numerator of three delays and a denominator of two delays: y[n] = 0.5·x[n] + x[n-1] + x[n-2] + 0.5·x[n-3] + 0.5·y[n-2]. Every coefficient is one or one half, so the arithmetic needs no multiplier. Inside the block, outputs carry `FRAC_W` fractional bits and three guard bits above the input width, so the feedback path never wraps. The value presented at the port is rounded towards minus infinity and clamped to the output width. One delay step for a slot equals one visit of that slot, however many cycles pass between visits. `NSLOT` must be a power of two, with at least two slots.

Top module: `tmiir_filter`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the history of every slot in both lanes to zero, drives `out_valid` low and sets `out_i` and `out_q` to zero.
- R2: A sample accepted with `in_valid` high at a rising edge gives `out_valid` high after exactly that edge, and `out_slot` equals the `in_slot` of that sample.
- R3: For each lane, the internal result, scaled by 2^FRAC_W, is v = x·2^(FRAC_W-1) + x1·2^FRAC_W + x2·2^FRAC_W + x3·2^(FRAC_W-1) + floor(v2/2). Here x is the new sample, and x1, x2, x3 are the slot's previous three inputs (newest first). v2 is the slot's scaled result from two visits earlier, kept at full precision.
- R4: The output value is floor(v / 2^FRAC_W), clamped to the range -2^(OUT_W-1) to 2^(OUT_W-1)-1 instead of wrapping.
- R5: A sample for one slot leaves the history of every other slot unchanged.
- R6: The I lane result depends only on `in_i` samples and the Q lane result only on `in_q` samples.
- R7: A cycle with `in_valid` low changes no slot history and gives `out_valid` low after that edge.
- R8: Slots may arrive in any order, including the same slot several times in a row; each visit advances only that slot's history by one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present this cycle |
| in_slot | input | $clog2(NSLOT) | Channel slot of the input sample |
| in_i | input | IN_W | In-phase sample, two's complement |
| in_q | input | IN_W | Quadrature sample, two's complement |
| out_valid | output | 1 | Filtered result present |
| out_slot | output | $clog2(NSLOT) | Slot of the filtered result |
| out_i | output | OUT_W | Filtered in-phase value, saturated |
| out_q | output | OUT_W | Filtered quadrature value, saturated |

## Verification
The assertions assume that `in_slot` always names an existing slot and that `in_valid` is a clean level, sampled only at rising edges. The checks on slot history follow from this: a slot not addressed in a cycle must hold still, and an addressed slot must shift its history by exactly one step. The stimulus drives inputs only away from the rising edge and uses slot numbers below `NSLOT` only. It holds `in_valid` low during reset. Its input values cover the full signed range, so that the clamp is exercised at both ends.

// File: rtl/tmiir_pkg.sv
package tmiir_pkg;
    // headroom above the input width: DC gain of the recursion is 6 (< 8)
    localparam int GUARD_BITS = 3;
    localparam int NUM_LANES  = 2;
    localparam int LANE_I     = 0;
    localparam int LANE_Q     = 1;
endpackage

// File: rtl/tmiir_kernel.sv
module tmiir_kernel #(
    parameter int IN_W   = 8,
    parameter int OUT_W  = 8,
    parameter int FRAC_W = 2,
    parameter int ACC_W  = 13
) (
    input  logic signed [IN_W-1:0]  x0,
    input  logic signed [IN_W-1:0]  x1,
    input  logic signed [IN_W-1:0]  x2,
    input  logic signed [IN_W-1:0]  x3,
    input  logic signed [ACC_W-1:0] v2,
    output logic signed [ACC_W-1:0] v_full,
    output logic signed [OUT_W-1:0] y_sat
);
    localparam logic signed [ACC_W-1:0] OMAX = ACC_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] OMIN = ACC_W'(-(2 ** (OUT_W - 1)));

    logic signed [ACC_W-1:0] half_now, one_a, one_b, half_old, fb_half, v_int;

    always_comb begin
        half_now = ACC_W'(x0) <<< (FRAC_W - 1);
        one_a    = ACC_W'(x1) <<< FRAC_W;
        one_b    = ACC_W'(x2) <<< FRAC_W;
        half_old = ACC_W'(x3) <<< (FRAC_W - 1);
        fb_half  = v2 >>> 1;
        v_full   = half_now + one_a + one_b + half_old + fb_half;
        v_int    = v_full >>> FRAC_W;
        if (v_int > OMAX) begin
            y_sat = OUT_W'(OMAX);
        end else if (v_int < OMIN) begin
            y_sat = OUT_W'(OMIN);
        end else begin
            y_sat = OUT_W'(v_int);
        end
    end
endmodule

// File: rtl/tmiir_lane.sv
module tmiir_lane #(
    parameter int NSLOT  = 4,
    parameter int IN_W   = 8,
    parameter int OUT_W  = 8,
    parameter int FRAC_W = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       smp_valid,
    input  logic [$clog2(NSLOT)-1:0]   smp_slot,
    input  logic signed [IN_W-1:0]     smp_x,
    output logic signed [OUT_W-1:0]    res_y
);
    import tmiir_pkg::*;

    localparam int SLOT_W = $clog2(NSLOT);
    localparam int ACC_W  = IN_W + GUARD_BITS + FRAC_W;

    typedef struct packed {
        logic signed [IN_W-1:0]  x1;
        logic signed [IN_W-1:0]  x2;
        logic signed [IN_W-1:0]  x3;
        logic signed [ACC_W-1:0] v1;
        logic signed [ACC_W-1:0] v2;
    } hist_t;

    typedef struct packed {
        hist_t [NSLOT-1:0]       hist;
        logic signed [OUT_W-1:0] y;
    } lane_st_t;

    lane_st_t st_d, st_q;
    hist_t    sel;
    logic signed [ACC_W-1:0] v_new;
    logic signed [OUT_W-1:0] y_new;

    assign sel = st_q.hist[smp_slot];

    tmiir_kernel #(
        .IN_W(IN_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)
    ) u_kernel (
        .x0(smp_x), .x1(sel.x1), .x2(sel.x2), .x3(sel.x3), .v2(sel.v2),
        .v_full(v_new), .y_sat(y_new)
    );

    always_comb begin
        st_d = st_q;
        if (smp_valid) begin
            st_d.hist[smp_slot].x1 = smp_x;
            st_d.hist[smp_slot].x2 = sel.x1;
            st_d.hist[smp_slot].x3 = sel.x2;
            st_d.hist[smp_slot].v1 = v_new;
            st_d.hist[smp_slot].v2 = sel.v1;
            st_d.y                 = y_new;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_y = st_q.y;

    for (genvar s = 0; s < NSLOT; s++) begin : g_chk
        // R5 R7
        untouched_slot_holds_chk: assert property (@(posedge clk) disable iff (rst)
            !(smp_valid && smp_slot == SLOT_W'(s)) |=> $stable(st_q.hist[s]));
        // R3
        history_shift_chk: assert property (@(posedge clk) disable iff (rst)
            (smp_valid && smp_slot == SLOT_W'(s)) |=>
                (st_q.hist[s].v2 == $past(st_q.hist[s].v1)) &&
                (st_q.hist[s].x2 == $past(st_q.hist[s].x1)) &&
                (st_q.hist[s].x3 == $past(st_q.hist[s].x2)));
    end
endmodule

// File: rtl/tmiir_filter.sv
module tmiir_filter #(
    parameter int NSLOT  = 4,
    parameter int IN_W   = 8,
    parameter int OUT_W  = 8,
    parameter int FRAC_W = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [$clog2(NSLOT)-1:0]   in_slot,
    input  logic signed [IN_W-1:0]     in_i,
    input  logic signed [IN_W-1:0]     in_q,
    output logic                       out_valid,
    output logic [$clog2(NSLOT)-1:0]   out_slot,
    output logic signed [OUT_W-1:0]    out_i,
    output logic signed [OUT_W-1:0]    out_q
);
    import tmiir_pkg::*;

    localparam int SLOT_W = $clog2(NSLOT);

    typedef struct packed {
        logic              valid;
        logic [SLOT_W-1:0] slot;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic signed [IN_W-1:0]  lane_x [NUM_LANES];
    logic signed [OUT_W-1:0] lane_y [NUM_LANES];

    assign lane_x[LANE_I] = in_i;
    assign lane_x[LANE_Q] = in_q;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        tmiir_lane #(
            .NSLOT(NSLOT), .IN_W(IN_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W)
        ) u_lane (
            .clk(clk), .rst(rst), .smp_valid(in_valid), .smp_slot(in_slot),
            .smp_x(lane_x[l]), .res_y(lane_y[l])
        );
    end

    always_comb begin
        ctl_d.valid = in_valid;
        ctl_d.slot  = in_valid ? in_slot : ctl_q.slot;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign out_valid = ctl_q.valid;
    assign out_slot  = ctl_q.slot;
    assign out_i     = lane_y[LANE_I];
    assign out_q     = lane_y[LANE_Q];

    // R1
    reset_clears_valid_chk: assert property (@(posedge clk) rst |=> !out_valid);
    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R7
    idle_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R2
    slot_tag_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_slot == $past(in_slot)));
endmodule

// File: tb/tb_tmiir_filter.sv
module tb_tmiir_filter;
    localparam int NS     = 4;
    localparam int IN_W   = 8;
    localparam int OUT_W  = 8;
    localparam int FRAC_W = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [1:0] in_slot = '0;
    logic signed [IN_W-1:0] in_i = '0;
    logic signed [IN_W-1:0] in_q = '0;
    logic out_valid;
    logic [1:0] out_slot;
    logic signed [OUT_W-1:0] out_i, out_q;

    int checks = 0;
    int errors = 0;
    string cur_req = "R3";
    bit done = 1'b0;

    typedef struct { int slot; int vi; int vq; } exp_t;
    exp_t expq[$];

    int mx1 [2][NS];
    int mx2 [2][NS];
    int mx3 [2][NS];
    int mv1 [2][NS];
    int mv2 [2][NS];

    always #5 clk = ~clk;

    tmiir_filter #(.NSLOT(NS), .IN_W(IN_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_slot(in_slot),
        .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_slot(out_slot),
        .out_i(out_i), .out_q(out_q)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic model_clear();
        for (int l = 0; l < 2; l++)
            for (int s = 0; s < NS; s++) begin
                mx1[l][s] = 0; mx2[l][s] = 0; mx3[l][s] = 0;
                mv1[l][s] = 0; mv2[l][s] = 0;
            end
    endtask

    // R3 recurrence and R4 floor + clamp, per lane and slot
    function automatic int model(input int l, input int s, input int x);
        int v, y;
        v = x * (1 << (FRAC_W - 1)) + mx1[l][s] * (1 << FRAC_W) + mx2[l][s] * (1 << FRAC_W)
            + mx3[l][s] * (1 << (FRAC_W - 1)) + (mv2[l][s] >>> 1);
        mx3[l][s] = mx2[l][s]; mx2[l][s] = mx1[l][s]; mx1[l][s] = x;
        mv2[l][s] = mv1[l][s]; mv1[l][s] = v;
        y = v >>> FRAC_W;
        if (y > 127) y = 127;
        if (y < -128) y = -128;
        return y;
    endfunction

    task automatic step(input bit v, input int s, input int xi, input int xq);
        exp_t e;
        @(negedge clk);
        #1;
        in_valid = v;
        in_slot  = 2'(s);
        in_i     = IN_W'(xi);
        in_q     = IN_W'(xq);
        if (v) begin
            e.slot = s;
            e.vi = model(0, s, xi);
            e.vq = model(1, s, xq);
            expq.push_back(e);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        #1;
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        // R1: outputs cleared while reset held
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);
        check(out_i == 0, "R1", int'(out_i), 0);
        check(out_q == 0, "R1", int'(out_q), 0);
        #1;
        rst = 1'b0;
        model_clear();
    endtask

    // monitor: scoreboard compare, samples at falling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (expq.size() > 0) begin
                exp_t e;
                e = expq.pop_front();
                check(out_valid == 1'b1, "R2", int'(out_valid), 1);
                check(int'(out_slot) == e.slot, "R2", int'(out_slot), e.slot);
                check(int'(out_i) == e.vi, cur_req, int'(out_i), e.vi);
                check(int'(out_q) == e.vq, cur_req, int'(out_q), e.vq);
            end else begin
                // R7: no sample, no valid
                check(out_valid == 1'b0, "R7", int'(out_valid), 0);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed = 7;
        int seq [6] = '{3, 3, 0, 2, 1, 0};
        model_clear();
        do_reset();

        // R3 R5 R6: impulse on I of slot 2 only, zeros elsewhere
        cur_req = "R5";
        for (int p = 0; p < 10; p++)
            for (int s = 0; s < NS; s++)
                step(1'b1, s, (p == 0 && s == 2) ? 64 : 0, 0);
        // R6: Q impulse on slot 1, with idle gaps (R7)
        cur_req = "R6";
        for (int p = 0; p < 10; p++)
            for (int s = 0; s < NS; s++) begin
                step(1'b1, s, 0, (p == 0 && s == 1) ? -100 : 0);
                if (s == 3) step(1'b0, 0, 55, -55);
            end
        // R4: DC drives both clamps
        cur_req = "R4";
        for (int p = 0; p < 12; p++)
            for (int s = 0; s < NS; s++)
                step(1'b1, s, 100, -128);
        for (int p = 0; p < 12; p++)
            for (int s = 0; s < NS; s++)
                step(1'b1, s, -128, 127);
        // R3: pseudo-random round robin with gaps
        cur_req = "R3";
        for (int p = 0; p < 40; p++)
            for (int s = 0; s < NS; s++) begin
                int a, b;
                seed = seed * 1103515245 + 12345;
                a = int'($signed(8'(seed >>> 16)));
                b = int'($signed(8'(seed >>> 8)));
                step(1'b1, s, a, b);
                if (((p + s) % 5) == 0) step(1'b0, 1, 3, 3);
            end
        // R8: irregular slot order with repeats
        cur_req = "R8";
        for (int p = 0; p < 30; p++)
            for (int k = 0; k < 6; k++)
                step(1'b1, seq[k], (p * 13 + k * 29) % 200 - 100, (k * 41 - p * 7) % 120);
        step(1'b0, 0, 0, 0);
        // R1: reset mid-run, then an impulse must see zero history
        do_reset();
        cur_req = "R1";
        for (int p = 0; p < 6; p++)
            for (int s = 0; s < NS; s++)
                step(1'b1, s, (p == 0) ? 40 : 0, (p == 0) ? -40 : 0);
        step(1'b0, 0, 0, 0);
        step(1'b0, 0, 0, 0);
        check(expq.size() == 0, "R2", expq.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule